// File: doc/BRIEF.md
# Stream Cipher Init and Keystream Sequencer

This block runs a word-oriented stream cipher from a 128-bit key and a 128-bit IV. It contains a sixteen-cell register over the field of integers modulo 2^31-1, a bit-reorganisation stage that picks four 32-bit words from that register, and a nonlinear filter with two 32-bit memory words. A sequencer state machine drives everything. When a start request is accepted it loads the register and clears the filter memory. It then runs a fixed number of initialisation rounds and one warm-up round whose output is discarded. After that it offers one 32-bit keystream word at a time on a valid/ready handshake.

The state machine has four states. `ST_IDLE` waits after reset. `ST_INIT` runs the initialisation rounds. `ST_WARM` runs the single warm-up round. `ST_EMIT` presents keystream words. The transitions are: *accept* from `ST_IDLE` or `ST_EMIT` to `ST_INIT`, taken on `start` and loading key and IV; *rounds_done* from `ST_INIT` to `ST_WARM`, taken after the last initialisation round; *warm_done* from `ST_WARM` to `ST_EMIT`, taken unconditionally; and *transfer*, a self-loop on `ST_EMIT` taken on `ks_valid && ks_ready`. In `ST_EMIT`, *transfer* advances the cipher by one working round.

The byte substitutions are computed and not tabulated. Both use field inversion, with 0 mapping to 0, followed by a fixed output mapping.

Top module: `zks_keystream_gen`

## Requirements
- R1: After reset, `ks_valid` and `busy` are 0, and they stay 0 until `start` is given.
- R2: On an accepted start, cell i (i = 0..15) is loaded with {key byte i, c_i, iv byte i}. The 31-bit cell takes the key byte in bits 30:23, c_i in bits 22:8 and the IV byte in bits 7:0. Byte 0 is bits 127:120 of `key` or `iv`. The 15-bit constants c_0..c_15 are 44D7, 26BC, 626B, 135E, 5789, 35E2, 7135, 09AF, 4D78, 2F13, 6BC4, 1AF1, 5E26, 3C4D, 789A, 47AC (hex). Filter words M1 and M2 are cleared to 0.
- R3: After the accepting clock edge, exactly 32 initialisation rounds and then one warm-up round run, one per cycle. `ks_valid` first rises 33 cycles after the accepting edge.
- R4: Word extraction uses the upper half of a cell, bits 30:15, and the lower half, bits 15:0. The words are A = {up(s15), lo(s14)}, B = {lo(s11), up(s9)}, C = {lo(s7), up(s5)} and D = {lo(s2), up(s0)}. The filter output is W = (A ^ M1) + M2 mod 2^32. The presented keystream word is W ^ D.
- R5: Every round updates the filter memory. With P = M1 + B mod 2^32 and Q = M2 ^ C, the new M1 is S(L1({P[15:0], Q[31:16]})) and the new M2 is S(L2({Q[15:0], P[31:16]})). Here L1(x) = x^rol(x,2)^rol(x,10)^rol(x,18)^rol(x,24) and L2(x) = x^rol(x,8)^rol(x,14)^rol(x,22)^rol(x,30).
- R6: S applies a byte map to each byte. Bytes 31:24 and 15:8 use map 0, which is inversion modulo x^8+x^4+x^3+x+1 followed by b^rol(b,1)^rol(b,2)^rol(b,3)^rol(b,4)^63h. Bytes 23:16 and 7:0 use map 1, which is inversion modulo x^8+x^7+x^3+x^2+1 followed by XOR with 55h.
- R7: Each register advance computes v = 2^15·s15 + 2^17·s13 + 2^21·s10 + 2^20·s4 + (1+2^8)·s0 mod 2^31-1. Initialisation rounds add W[31:1] to v modulo 2^31-1. A result of 0 is replaced by 2^31-1. The cells then shift down and v enters cell 15.
- R8: A `start` while `busy` is 1 is ignored: the run in progress and its keystream are unaffected.
- R9: `busy` is 1 from the cycle after an accepted start until the cycle in which `ks_valid` first rises, and is 0 otherwise.
- R10: In `ST_EMIT`, a word is consumed and the cipher advances one working round only on a cycle with `ks_valid && ks_ready`. While `ks_ready` is 0, `ks_word` and `ks_valid` hold.
- R11: A `start` while keystream is being offered reloads the cipher with the new key and IV. It takes priority over a transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load key/IV and begin a run |
| key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| iv | input | 128 | Initial vector, byte 0 in bits 127:120 |
| ks_ready | input | 1 | Consumer accepts the presented word |
| ks_valid | output | 1 | A keystream word is presented |
| ks_word | output | 32 | Presented keystream word |
| busy | output | 1 | Load and initialisation in progress |

## Verification
The in-line assertions watch properties that must hold on every cycle. They check that the round counter runs unbroken through the initialisation phase, that the warm-up round lasts exactly one cycle, and that a stalled word holds steady. They also check that `busy` falls only as `ks_valid` rises, that every new head cell is nonzero, and that the filter memory is zero after a clear. Only the bench scenarios show that the keystream values are right, by comparison with an independent arithmetic model of the load, the 33 discarded rounds and the working rounds. The same scenarios show the exact 33-cycle latency, that a start during a run is ignored, and that a start during emission reloads the cipher.

// File: rtl/zks_pkg.sv
package zks_pkg;

    localparam int NCELL   = 16;
    localparam int CELL_W  = 31;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int CONST_W = 15;
    localparam int KEY_W   = NCELL * BYTE_W;
    localparam int HALF_W  = WORD_W / 2;

    localparam logic [CELL_W-1:0] MOD_ALL1 = {CELL_W{1'b1}};

    typedef logic [CELL_W-1:0] cell_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_WARM,
        ST_EMIT
    } zks_state_t;

    // Cyclic left rotation of a 31-bit cell (multiplication by 2^k mod 2^31-1)
    function automatic cell_t rot31(input cell_t a, input int k);
        return (a << k) | (a >> (CELL_W - k));
    endfunction

    // Addition modulo 2^31-1 with end-around carry
    function automatic cell_t add31(input cell_t a, input cell_t b);
        logic [CELL_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[CELL_W-1:0] + {{(CELL_W-1){1'b0}}, t[CELL_W]};
    endfunction

    function automatic word_t rotl32(input word_t x, input int k);
        return (x << k) | (x >> (WORD_W - k));
    endfunction

    function automatic word_t lin_one(input word_t x);
        return x ^ rotl32(x, 2) ^ rotl32(x, 10) ^ rotl32(x, 18) ^ rotl32(x, 24);
    endfunction

    function automatic word_t lin_two(input word_t x);
        return x ^ rotl32(x, 8) ^ rotl32(x, 14) ^ rotl32(x, 22) ^ rotl32(x, 30);
    endfunction

    // Fixed 15-bit fill placed between key byte and IV byte of each cell
    function automatic logic [CONST_W-1:0] fill_const(input int i);
        logic [CONST_W-1:0] c;
        case (i)
            0:  c = 15'h44D7;
            1:  c = 15'h26BC;
            2:  c = 15'h626B;
            3:  c = 15'h135E;
            4:  c = 15'h5789;
            5:  c = 15'h35E2;
            6:  c = 15'h7135;
            7:  c = 15'h09AF;
            8:  c = 15'h4D78;
            9:  c = 15'h2F13;
            10: c = 15'h6BC4;
            11: c = 15'h1AF1;
            12: c = 15'h5E26;
            13: c = 15'h3C4D;
            14: c = 15'h789A;
            default: c = 15'h47AC;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/zks_sbox.sv
module zks_sbox
    import zks_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    localparam logic [BYTE_W-1:0] POLY_LO = (VARIANT == 0) ? 8'h1B : 8'h8D;
    localparam logic [BYTE_W-1:0] EXP_INV = 8'hFE;

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[BYTE_W-1] ? ((sh << 1) ^ POLY_LO) : (sh << 1);
        end
        return acc;
    endfunction

    // a^254 gives the inverse; 0 maps to 0
    function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] r;
        r = 8'h01;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (EXP_INV[i]) r = gf_mul(r, a);
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rol8(input logic [BYTE_W-1:0] x, input int k);
        return (x << k) | (x >> (BYTE_W - k));
    endfunction

    logic [BYTE_W-1:0] inv_b;

    always_comb begin
        inv_b = gf_inv(din);
    end

    generate
        if (VARIANT == 0) begin : g_affine
            always_comb begin
                dout = inv_b ^ rol8(inv_b, 1) ^ rol8(inv_b, 2) ^ rol8(inv_b, 3)
                     ^ rol8(inv_b, 4) ^ 8'h63;
            end
        end else begin : g_xorc
            always_comb begin
                dout = inv_b ^ 8'h55;
            end
        end
    endgenerate

endmodule

// File: rtl/zks_lfsr.sv
module zks_lfsr
    import zks_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              init_mode,
    input  logic [KEY_W-1:0]  key,
    input  logic [KEY_W-1:0]  iv,
    input  cell_t             fb_in,
    output word_t             x_a,
    output word_t             x_b,
    output word_t             x_c,
    output word_t             x_d
);

    localparam int UP_LSB = CELL_W - HALF_W;

    cell_t cell_q [NCELL];
    cell_t sum_work;
    cell_t sum_sel;
    cell_t head_nxt;

    always_comb begin
        sum_work = add31(add31(add31(rot31(cell_q[15], 15), rot31(cell_q[13], 17)),
                               add31(rot31(cell_q[10], 21), rot31(cell_q[4], 20))),
                         add31(rot31(cell_q[0], 8), cell_q[0]));
        sum_sel  = init_mode ? add31(sum_work, fb_in) : sum_work;
        head_nxt = (sum_sel == '0) ? MOD_ALL1 : sum_sel;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCELL; gi++) begin : g_cell
            localparam int KOFF = (NCELL - 1 - gi) * BYTE_W;
            if (gi == NCELL - 1) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        cell_q[gi] <= '0;
                    end else if (load) begin
                        cell_q[gi] <= {key[KOFF +: BYTE_W], fill_const(gi), iv[KOFF +: BYTE_W]};
                    end else if (adv) begin
                        cell_q[gi] <= head_nxt;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        cell_q[gi] <= '0;
                    end else if (load) begin
                        cell_q[gi] <= {key[KOFF +: BYTE_W], fill_const(gi), iv[KOFF +: BYTE_W]};
                    end else if (adv) begin
                        cell_q[gi] <= cell_q[gi+1];
                    end
                end
            end
        end
    endgenerate

    // Word extraction: upper half = bits 30:15, lower half = bits 15:0
    always_comb begin
        x_a = {cell_q[15][CELL_W-1:UP_LSB], cell_q[14][HALF_W-1:0]};
        x_b = {cell_q[11][HALF_W-1:0],      cell_q[9][CELL_W-1:UP_LSB]};
        x_c = {cell_q[7][HALF_W-1:0],       cell_q[5][CELL_W-1:UP_LSB]};
        x_d = {cell_q[2][HALF_W-1:0],       cell_q[0][CELL_W-1:UP_LSB]};
    end

    // R7: the newly entered head cell is never zero
    a_r7_head_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv) && !$past(load)) |-> (cell_q[NCELL-1] != '0));

    // R2: after a load the head cell carries its fixed fill
    a_r2_load_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (cell_q[NCELL-1][CONST_W+BYTE_W-1:BYTE_W] == fill_const(NCELL-1)));

endmodule

// File: rtl/zks_filter.sv
module zks_filter
    import zks_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  step,
    input  word_t x_a,
    input  word_t x_b,
    input  word_t x_c,
    output word_t w_out
);

    localparam int NBYTE = WORD_W / BYTE_W;

    word_t mem1_q, mem2_q;
    word_t mix_p, mix_q;
    word_t lin1_v, lin2_v;
    word_t sub1_v, sub2_v;

    always_comb begin
        w_out  = (x_a ^ mem1_q) + mem2_q;
        mix_p  = mem1_q + x_b;
        mix_q  = mem2_q ^ x_c;
        lin1_v = lin_one({mix_p[HALF_W-1:0], mix_q[WORD_W-1:HALF_W]});
        lin2_v = lin_two({mix_q[HALF_W-1:0], mix_p[WORD_W-1:HALF_W]});
    end

    // Byte lanes: even lane index from the top uses map 0, odd uses map 1
    genvar gb;
    generate
        for (gb = 0; gb < NBYTE; gb++) begin : g_lane
            localparam int LSB = (NBYTE - 1 - gb) * BYTE_W;
            zks_sbox #(.VARIANT(gb % 2)) u_sb1 (
                .din  (lin1_v[LSB +: BYTE_W]),
                .dout (sub1_v[LSB +: BYTE_W])
            );
            zks_sbox #(.VARIANT(gb % 2)) u_sb2 (
                .din  (lin2_v[LSB +: BYTE_W]),
                .dout (sub2_v[LSB +: BYTE_W])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem1_q <= '0;
            mem2_q <= '0;
        end else if (clear) begin
            mem1_q <= '0;
            mem2_q <= '0;
        end else if (step) begin
            mem1_q <= sub1_v;
            mem2_q <= sub2_v;
        end
    end

    // R2: a clear leaves both memory words at zero
    a_r2_mem_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (mem1_q == '0 && mem2_q == '0));

endmodule

// File: rtl/zks_ctrl.sv
module zks_ctrl
    import zks_pkg::*;
#(
    parameter int INIT_ROUNDS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ready,
    output logic lfsr_load,
    output logic lfsr_adv,
    output logic lfsr_init,
    output logic f_clear,
    output logic f_step,
    output logic ks_valid,
    output logic busy
);

    localparam int CNT_W = $clog2(INIT_ROUNDS + 1);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(INIT_ROUNDS - 1);

    zks_state_t state_q, state_d;
    logic [CNT_W-1:0] rnd_q;
    logic accept;

    always_comb begin
        accept = start && (state_q == ST_IDLE || state_q == ST_EMIT);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_INIT;
            ST_INIT: if (rnd_q == LAST_RND) state_d = ST_WARM;
            ST_WARM: state_d = ST_EMIT;
            ST_EMIT: if (accept) state_d = ST_INIT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= '0;
        end else if (accept) begin
            rnd_q <= '0;
        end else if (state_q == ST_INIT) begin
            rnd_q <= rnd_q + 1'b1;
        end
    end

    always_comb begin
        lfsr_load = accept;
        f_clear   = accept;
        lfsr_init = 1'b0;
        lfsr_adv  = 1'b0;
        ks_valid  = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin
                lfsr_adv  = 1'b1;
                lfsr_init = 1'b1;
                busy      = 1'b1;
            end
            ST_WARM: begin
                lfsr_adv = 1'b1;
                busy     = 1'b1;
            end
            ST_EMIT: begin
                ks_valid = 1'b1;
                lfsr_adv = ready && !accept;
            end
            default: ;
        endcase
        f_step = lfsr_adv;
    end

    // R8: a start during initialisation never restarts the round count
    a_r8_rounds_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && $past(state_q) == ST_INIT) |-> (rnd_q == $past(rnd_q) + 1'b1));

    // R3: the last initialisation round is followed by warm-up
    a_r3_init_to_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT && rnd_q == LAST_RND) |=> (state_q == ST_WARM));

    // R3: exactly one warm-up round
    a_r3_single_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM) |=> (state_q == ST_EMIT));

    // R9: busy drops only when the first word appears
    a_r9_busy_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ks_valid);

    // R9: an accepted start raises busy
    a_r9_load_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_load |=> busy);

endmodule

// File: rtl/zks_keystream_gen.sv
module zks_keystream_gen
    import zks_pkg::*;
#(
    parameter int INIT_ROUNDS = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] key,
    input  logic [127:0] iv,
    input  logic         ks_ready,
    output logic         ks_valid,
    output logic [31:0]  ks_word,
    output logic         busy
);

    logic  lfsr_load, lfsr_adv, lfsr_init, f_clear, f_step;
    word_t x_a, x_b, x_c, x_d;
    word_t w_val;
    cell_t fb_val;

    zks_ctrl #(.INIT_ROUNDS(INIT_ROUNDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ready     (ks_ready),
        .lfsr_load (lfsr_load),
        .lfsr_adv  (lfsr_adv),
        .lfsr_init (lfsr_init),
        .f_clear   (f_clear),
        .f_step    (f_step),
        .ks_valid  (ks_valid),
        .busy      (busy)
    );

    zks_lfsr u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lfsr_load),
        .adv       (lfsr_adv),
        .init_mode (lfsr_init),
        .key       (key),
        .iv        (iv),
        .fb_in     (fb_val),
        .x_a       (x_a),
        .x_b       (x_b),
        .x_c       (x_c),
        .x_d       (x_d)
    );

    zks_filter u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (f_clear),
        .step  (f_step),
        .x_a   (x_a),
        .x_b   (x_b),
        .x_c   (x_c),
        .w_out (w_val)
    );

    always_comb begin
        fb_val  = w_val[WORD_W-1:1];
        ks_word = w_val ^ x_d;
    end

    // R10: a stalled word and its valid hold
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !ks_ready && !start) |=> (ks_valid && $stable(ks_word)));

    // R1: nothing is offered or busy without a start since reset
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ks_valid && !busy && !start) |=> (!ks_valid && !busy));

endmodule

// File: tb/zks_keystream_gen_tb.sv
module zks_keystream_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam longint MODP   = 64'd2147483647;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [127:0] key, iv;
    logic         ks_ready;
    logic         ks_valid;
    logic [31:0]  ks_word;
    logic         busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zks_keystream_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .key      (key),
        .iv       (iv),
        .ks_ready (ks_ready),
        .ks_valid (ks_valid),
        .ks_word  (ks_word),
        .busy     (busy)
    );

    // ---------------- reference model ----------------
    logic [7:0]  map0 [256];
    logic [7:0]  map1 [256];
    logic [14:0] fills [16] = '{15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2,
                                15'h7135, 15'h09AF, 15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1,
                                15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC};
    logic [30:0] mc [16];
    logic [31:0] mr1, mr2;

    function automatic logic [7:0] bmul(logic [7:0] a, logic [7:0] b, logic [8:0] poly);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'(poly) << (i - 8));
        return prod[7:0];
    endfunction

    task automatic build_maps();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] i0, i1, a;
            i0 = 8'h00; i1 = 8'h00;
            for (int y = 1; y < 256; y++) begin
                if (bmul(8'(x), 8'(y), 9'h11B) == 8'h01) i0 = 8'(y);
                if (bmul(8'(x), 8'(y), 9'h18D) == 8'h01) i1 = 8'(y);
            end
            for (int b = 0; b < 8; b++)
                a[b] = i0[b] ^ i0[(b+4)%8] ^ i0[(b+5)%8] ^ i0[(b+6)%8] ^ i0[(b+7)%8];
            map0[x] = a ^ 8'h63;
            map1[x] = i1 ^ 8'h55;
        end
    endtask

    function automatic logic [31:0] brot(logic [31:0] x, int k);
        logic [63:0] d;
        d = {x, x} << k;
        return d[63:32];
    endfunction

    function automatic logic [31:0] bsub(logic [31:0] x);
        return {map0[x[31:24]], map1[x[23:16]], map0[x[15:8]], map1[x[7:0]]};
    endfunction

    function automatic longint mterm(logic [30:0] s, int k);
        return ((longint'(s) % MODP) << k) % MODP;
    endfunction

    task automatic mload(logic [127:0] k, logic [127:0] v);
        for (int i = 0; i < 16; i++) mc[i] = {k[127-8*i -: 8], fills[i], v[127-8*i -: 8]};
        mr1 = '0;
        mr2 = '0;
    endtask

    function automatic logic [31:0] mpeek();
        logic [31:0] xa, xd;
        xa = {mc[15][30:15], mc[14][15:0]};
        xd = {mc[2][15:0], mc[0][30:15]};
        return ((xa ^ mr1) + mr2) ^ xd;
    endfunction

    task automatic mround(bit init_mode);
        logic [31:0] xa, xb, xc, w, p, q;
        longint v;
        xa = {mc[15][30:15], mc[14][15:0]};
        xb = {mc[11][15:0], mc[9][30:15]};
        xc = {mc[7][15:0], mc[5][30:15]};
        w  = (xa ^ mr1) + mr2;
        p  = mr1 + xb;
        q  = mr2 ^ xc;
        begin
            logic [31:0] t1, t2;
            t1 = {p[15:0], q[31:16]};
            t2 = {q[15:0], p[31:16]};
            mr1 = bsub(t1 ^ brot(t1, 2) ^ brot(t1, 10) ^ brot(t1, 18) ^ brot(t1, 24));
            mr2 = bsub(t2 ^ brot(t2, 8) ^ brot(t2, 14) ^ brot(t2, 22) ^ brot(t2, 30));
        end
        v = (mterm(mc[15], 15) + mterm(mc[13], 17) + mterm(mc[10], 21)
           + mterm(mc[4], 20) + mterm(mc[0], 8) + mterm(mc[0], 0)) % MODP;
        if (init_mode) v = (v + longint'(w[31:1])) % MODP;
        if (v == 0) v = MODP;
        for (int i = 0; i < 15; i++) mc[i] = mc[i+1];
        mc[15] = v[30:0];
    endtask

    // ---------------- checking helpers ----------------
    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // Start a run and follow it through the first nwords transfers.
    task automatic session(logic [127:0] k, logic [127:0] v, int nwords, bit poke_busy);
        bit bad_phase;
        logic [31:0] exp_w;
        logic [31:0] held;
        bit stalled;
        key   = k;
        iv    = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        key   = ~k;
        iv    = ~v;
        mload(k, v);
        for (int r = 0; r < 32; r++) mround(1'b1);
        mround(1'b0);
        bad_phase = 1'b0;
        for (int n = 0; n <= 32; n++) begin
            if (n > 0) @(negedge clk);
            if (!(busy === 1'b1 && ks_valid === 1'b0)) bad_phase = 1'b1;
            if (poke_busy && n == 10) start = 1'b1;
            if (poke_busy && n == 11) start = 1'b0;
        end
        start = 1'b0;
        check(!bad_phase, "R9 busy during init", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check(ks_valid === 1'b1, "R3 valid after 33 cycles", {31'd0, ks_valid}, 32'd1);
        check(busy === 1'b0, "R9 busy low with first word", {31'd0, busy}, 32'd0);
        stalled = 1'b0;
        held    = '0;
        for (int j = 0; j < nwords; ) begin
            exp_w = mpeek();
            if (stalled)
                check(ks_word === held && ks_valid === 1'b1, "R10 stall hold", ks_word, held);
            if (poke_busy)
                check(ks_word === exp_w, "R8 busy start ignored", ks_word, exp_w);
            else
                check(ks_word === exp_w, "R4 R5 R6 R7 keystream word", ks_word, exp_w);
            ks_ready = ($urandom % 4) != 0;
            if (ks_ready) begin
                mround(1'b0);
                j++;
                stalled = 1'b0;
            end else begin
                stalled = 1'b1;
                held    = ks_word;
            end
            @(negedge clk);
        end
        ks_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_maps();
        rst_n    = 1'b0;
        start    = 1'b0;
        ks_ready = 1'b0;
        key      = '0;
        iv       = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ks_valid === 1'b0, "R1 reset valid", {31'd0, ks_valid}, 32'd0);
        check(busy === 1'b0, "R1 reset busy", {31'd0, busy}, 32'd0);

        // Directed corners: all-zero and all-one key and IV (R2 load format)
        session('0, '0, 8, 1'b0);
        // R11: this start arrives while words are being offered
        session({128{1'b1}}, {128{1'b1}}, 6, 1'b0);
        // R8: start pulse in the middle of initialisation with a different key
        session({4{$urandom()}}, {4{$urandom()}}, 10, 1'b1);
        for (int s = 0; s < 4; s++)
            session({$urandom(), $urandom(), $urandom(), $urandom()},
                    {$urandom(), $urandom(), $urandom(), $urandom()}, 20, 1'b0);

        // R11: start and ready in the same cycle, start wins and reloads
        key      = 128'h0123456789ABCDEF_FEDCBA9876543210;
        iv       = 128'h00112233445566778899AABBCCDDEEFF;
        ks_ready = 1'b1;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start    = 1'b0;
        ks_ready = 1'b0;
        mload(128'h0123456789ABCDEF_FEDCBA9876543210, 128'h00112233445566778899AABBCCDDEEFF);
        for (int r = 0; r < 32; r++) mround(1'b1);
        mround(1'b0);
        repeat (33) @(negedge clk);
        check(ks_valid === 1'b1, "R11 reload valid", {31'd0, ks_valid}, 32'd1);
        check(ks_word === mpeek(), "R11 reload word", ks_word, mpeek());

        finish_run();
    end

endmodule